// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog down-counter that software can only steer by writing 16-bit magic values to a key register. One key starts it. A second key refills the counter, which is how software keeps the system alive. Two more keys open and close write access to the prescaler and reload registers. Once started, the watchdog keeps running until the next system reset. If software stops refreshing it, the counter runs down to zero and the block emits a one-cycle reset request.

A single-cycle write port carries a 2-bit address and 16-bit data, with this map:

| Address | Register |
|---|---|
| 0 | Key |
| 1 | Prescaler code, data bits [2:0] |
| 2 | Reload value, data bits [11:0] |

Address 3 is unused. The counter value is brought out so its progress can be observed. The whole block runs on one clock.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the counter output reads 0xFFF, the timeout output is low, the prescaler code is 0 and the reload value is 0xFFF. The block stays idle, so the counter holds and no timeout occurs until it is started.
- R2: Writing key 0xCCCC while idle loads the counter from the reload register, clears the divider and starts the watchdog. The counter then drops by one every D clock cycles, with the first drop D cycles after the start write.
- R3: Writing key 0xAAAA loads the counter from the reload register, restarts the divider and removes write access to the prescaler and reload registers. Refreshing faster than the timeout period prevents any timeout.
- R4: Writing key 0x5555 grants write access to the prescaler (address 1) and reload (address 2) registers. Writing key 0x0000 withdraws that access.
- R5: Writes to address 1 or address 2 while access is not granted leave the registers unchanged.
- R6: Prescaler codes 0 to 6 set the divisor D to 4, 8, 16, 32, 64, 128 and 256 respectively. Code 7 also sets D to 256.
- R7: The running counter reaches zero and then completes one further divider period. At that point the timeout output is high for exactly one cycle and the counter is refilled from the reload register. The period from start or refresh to timeout is therefore (reload+1)*D cycles.
- R8: Key values other than the four defined keys have no effect. A start key written while running has no effect. No key stops a running watchdog.
- R9: A new reload value written while running does not change the current count. It is used at the next refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one write per cycle |
| wrAddr | input | 2 | Register address |
| wrData | input | 16 | Write data |
| countOut | output | 12 | Current down-counter value |
| timeoutPulse | output | 1 | One-cycle reset request |

## Verification
Every write takes effect at the clock edge that samples it. A refill, lock change or start is therefore visible at the first falling edge after the write. The first counter decrement is due exactly D rising edges after a start or refresh, and the timeout pulse is due (reload+1)*D edges after it. The bench counts rising edges from the write that started the interval and samples on the following falling edge. This places each comparison on the exact cycle the result is due, and never on the edge that produces it. Writes that must have no effect are followed by a refresh or a timed run, so their absence shows up in the counter or the timeout period.

// File: rtl/keyed_watchdog_pkg.sv
package keyed_watchdog_pkg;
  localparam int ADDR_W = 2;
  localparam int KEY_W  = 16;

  localparam logic [ADDR_W-1:0] ADDR_KEY = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PSC = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RLD = 2'd2;

  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_LOCK    = 16'h0000;

  // control -> datapath strobes
  typedef struct packed {
    logic start;
    logic refresh;
    logic pscWe;
    logic rldWe;
    logic run;
  } wdgStrobe_t;
endpackage

// File: rtl/keyed_watchdog_ctrl.sv
module keyed_watchdog_ctrl
  import keyed_watchdog_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output wdgStrobe_t        stb
);
  logic unlockedQ;
  logic runQ;
  logic keyHit;
  logic [KEY_W-1:0] keyVal;

  assign keyHit = wrEn && (wrAddr == ADDR_KEY);
  assign keyVal = wrData[KEY_W-1:0];

  always_comb begin
    stb.start   = keyHit && (keyVal == KEY_START) && !runQ;
    stb.refresh = keyHit && (keyVal == KEY_REFRESH);
    stb.pscWe   = wrEn && (wrAddr == ADDR_PSC) && unlockedQ;
    stb.rldWe   = wrEn && (wrAddr == ADDR_RLD) && unlockedQ;
    stb.run     = runQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unlockedQ <= 1'b0;
      runQ      <= 1'b0;
    end else if (keyHit) begin
      case (keyVal)
        KEY_REFRESH: unlockedQ <= 1'b0;
        KEY_UNLOCK:  unlockedQ <= 1'b1;
        KEY_LOCK:    unlockedQ <= 1'b0;
        KEY_START:   runQ      <= 1'b1;
        default: ;
      endcase
    end
  end

  // R8: a running watchdog stays running
  assert_run_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    runQ |=> runQ);

  // R3: a refresh leaves the configuration locked
  assert_refresh_locks_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.refresh |=> !unlockedQ);

  // R4: access is granted exactly after an unlock key
  assert_unlock_grants_R4: assert property (@(posedge clk) disable iff (!rstN)
    (keyHit && keyVal == KEY_UNLOCK) |=> unlockedQ);
endmodule

// File: rtl/keyed_watchdog_datapath.sv
module keyed_watchdog_datapath
  import keyed_watchdog_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int RLD_W      = 12,
  parameter int PSC_W      = 3,
  parameter int BASE_SHIFT = 2,
  parameter int MAX_SHIFT  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdgStrobe_t       stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [RLD_W-1:0] countOut,
  output logic             timeoutPulse
);
  localparam int DIV_W = BASE_SHIFT + MAX_SHIFT;

  logic [PSC_W-1:0] pscQ;
  logic [RLD_W-1:0] rldQ;
  logic [RLD_W-1:0] cntQ;
  logic [DIV_W-1:0] divCntQ;
  logic             pulseQ;
  logic [PSC_W-1:0] effShift;
  logic [DIV_W:0]   divLastWide;
  logic [DIV_W-1:0] divLast;
  logic             tick;

  // codes above the top divisor saturate
  assign effShift    = (pscQ > PSC_W'(MAX_SHIFT)) ? PSC_W'(MAX_SHIFT) : pscQ;
  assign divLastWide = ((DIV_W+1)'(1) << (BASE_SHIFT + int'(effShift))) - (DIV_W+1)'(1);
  assign divLast     = divLastWide[DIV_W-1:0];
  // >= copes with a divisor shrunk mid-period
  assign tick        = stb.run && (divCntQ >= divLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pscQ    <= '0;
      rldQ    <= '1;
      cntQ    <= '1;
      divCntQ <= '0;
      pulseQ  <= 1'b0;
    end else begin
      pulseQ <= 1'b0;
      if (stb.pscWe) pscQ <= wrData[PSC_W-1:0];
      if (stb.rldWe) rldQ <= wrData[RLD_W-1:0];
      if (stb.start || stb.refresh) begin
        cntQ    <= rldQ;
        divCntQ <= '0;
      end else if (stb.run) begin
        if (tick) begin
          divCntQ <= '0;
          if (cntQ == '0) begin
            cntQ   <= rldQ;
            pulseQ <= 1'b1;
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end else begin
          divCntQ <= divCntQ + 1'b1;
        end
      end
    end
  end

  assign countOut     = cntQ;
  assign timeoutPulse = pulseQ;

  // R1: idle and untouched, the count holds
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.run && !stb.start && !stb.refresh) |=> $stable(cntQ));

  // R7: pulse lasts one cycle
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |=> !pulseQ);

  // R7: a pulse comes with a refill from the reload register
  assert_pulse_refill_R7: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |-> (cntQ == $past(rldQ)));

  // R8: no timeout unless running
  assert_pulse_needs_run_R8: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |-> $past(stb.run));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import keyed_watchdog_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int RLD_W      = 12,
  parameter int PSC_W      = 3,
  parameter int BASE_SHIFT = 2,
  parameter int MAX_SHIFT  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [RLD_W-1:0]  countOut,
  output logic              timeoutPulse
);
  wdgStrobe_t stb;

  keyed_watchdog_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .stb    (stb)
  );

  keyed_watchdog_datapath #(
    .DATA_W     (DATA_W),
    .RLD_W      (RLD_W),
    .PSC_W      (PSC_W),
    .BASE_SHIFT (BASE_SHIFT),
    .MAX_SHIFT  (MAX_SHIFT)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .wrData       (wrData),
    .countOut     (countOut),
    .timeoutPulse (timeoutPulse)
  );
endmodule

// File: tb/keyed_watchdog_tb_top.sv
`timescale 1ns/1ps
module keyed_watchdog_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic [11:0] countOut;
  logic        timeoutPulse;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  keyed_watchdog dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .countOut(countOut), .timeoutPulse(timeoutPulse)
  );

  // stimulus/expectation table: prescaler code, reload, cycles to timeout
  localparam int NV = 8;
  localparam int VCODE [NV] = '{0, 1, 2, 3, 4, 5, 6, 7};
  localparam int VRLD  [NV] = '{3, 0, 2, 5, 0, 2, 1, 1};
  localparam int VEXP  [NV] = '{16, 8, 48, 192, 64, 384, 512, 512};

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  // rising edges until the pulse is seen, -1 on limit
  task automatic waitPulse(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); @(negedge clk);
      if (timeoutPulse) begin n = i; break; end
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int n;
    int pulses;
    // table walk: R6, R7, R2
    for (int v = 0; v < NV; v++) begin
      doReset();
      wr(2'd0, 16'h5555);
      wr(2'd1, 16'(VCODE[v]));
      wr(2'd2, 16'(VRLD[v]));
      wr(2'd0, 16'hCCCC);
      waitPulse(2000, n);
      chk($sformatf("R6 period code %0d", VCODE[v]), n, VEXP[v]);
      chk("R7 refill at pulse", int'(countOut), VRLD[v]);
      cyc(1);
      chk("R7 pulse one cycle", int'(timeoutPulse), 0);
      waitPulse(2000, n);
      chk("R7 repeat period", n, VEXP[v] - 1);
    end

    // R1 reset state and idle
    doReset();
    chk("R1 reset count", int'(countOut), 12'hFFF);
    chk("R1 reset pulse", int'(timeoutPulse), 0);
    pulses = 0;
    for (int i = 0; i < 300; i++) begin cyc(1); if (timeoutPulse) pulses++; end
    chk("R1 idle no pulse", pulses, 0);
    chk("R1 idle holds count", int'(countOut), 12'hFFF);
    wr(2'd0, 16'h5555); wr(2'd2, 16'd1); wr(2'd0, 16'hCCCC);
    waitPulse(100, n);
    chk("R1 default prescaler divides by 4", n, 8);

    // R5 locked writes ignored
    doReset();
    wr(2'd2, 16'd5); wr(2'd0, 16'hAAAA);
    chk("R5 locked reload ignored", int'(countOut), 12'hFFF);
    wr(2'd1, 16'd6);
    wr(2'd0, 16'h5555); wr(2'd2, 16'd0); wr(2'd0, 16'hCCCC);
    waitPulse(2000, n);
    chk("R5 locked prescaler ignored", n, 4);

    // R4 unlock and lock keys, R3 refresh relocks
    doReset();
    wr(2'd0, 16'h5555); wr(2'd0, 16'h0000); wr(2'd2, 16'd7); wr(2'd0, 16'hAAAA);
    chk("R4 lock key withdraws access", int'(countOut), 12'hFFF);
    wr(2'd0, 16'h5555); wr(2'd2, 16'd5); wr(2'd0, 16'hAAAA);
    chk("R4 unlock grants reload write", int'(countOut), 5);
    wr(2'd2, 16'd9); wr(2'd0, 16'hAAAA);
    chk("R3 refresh relocks", int'(countOut), 5);

    // R8 unknown keys
    doReset();
    wr(2'd0, 16'h5555); wr(2'd0, 16'h1234); wr(2'd2, 16'd6); wr(2'd0, 16'hAAAA);
    chk("R8 unknown key keeps access", int'(countOut), 6);
    wr(2'd0, 16'hCCCD);
    cyc(20);
    chk("R8 near-start key does not start", int'(countOut), 6);

    // R2 first decrement timing
    doReset();
    wr(2'd0, 16'h5555); wr(2'd2, 16'd5); wr(2'd0, 16'hCCCC);
    chk("R2 start loads reload", int'(countOut), 5);
    cyc(3);
    chk("R2 holds before D cycles", int'(countOut), 5);
    cyc(1);
    chk("R2 decrement after D cycles", int'(countOut), 4);

    // R9 reload change while running
    wr(2'd0, 16'h5555); wr(2'd2, 16'd2);
    chk("R9 count unaffected by reload write", int'(countOut), 4);
    wr(2'd0, 16'hAAAA);
    chk("R9 new reload used at refill", int'(countOut), 2);

    // R3 periodic refresh prevents timeout (period 16)
    doReset();
    wr(2'd0, 16'h5555); wr(2'd2, 16'd3); wr(2'd0, 16'hCCCC);
    pulses = 0;
    for (int k = 0; k < 10; k++) begin
      for (int i = 0; i < 9; i++) begin cyc(1); if (timeoutPulse) pulses++; end
      wr(2'd0, 16'hAAAA);
      if (timeoutPulse) pulses++;
    end
    chk("R3 refresh prevents timeout", pulses, 0);
    cyc(3);
    chk("R3 divider restarted by refresh", int'(countOut), 3);

    // R8 cannot stop, start while running ignored (period 8)
    doReset();
    wr(2'd0, 16'h5555); wr(2'd2, 16'd1); wr(2'd0, 16'hCCCC);
    wr(2'd0, 16'h0000); wr(2'd0, 16'h5555); wr(2'd0, 16'hCCCC);
    waitPulse(100, n);
    chk("R8 keys do not stop or restart", n + 3, 8);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule